// File: doc/BRIEF.md
# Far-End and Near-End Block Error Status Generator

This block keeps the line-quality status bits of a digital subscriber loop transceiver, updated once per superframe. At each superframe boundary it takes the far-end block error bit sent by the remote end and the CRC verdict for the superframe just received. From these it keeps a latched received far-end bit and a computed near-end bit. Both are updated only while the receiver holds superframe sync and the link is up.

It also builds the outgoing far-end block error bit. Software writes a request bit, which is sampled at the end of basic frame 8. The outgoing value goes onto the line at the end of basic frame 2. In automatic mode the local near-end status and the software request are merged, so either one can flag an error. In forced mode the software request is sent unchanged. All of these status bits are active low: 0 reports an error.

Two saturating counters record superframes with far-end errors and superframes with near-end errors, for performance monitoring. Software can clear both counters with a strobe. CRC computation and frame alignment happen upstream.

Top module: `fbe_status_gen`

## Requirements
- R1: When `sf_end` is high while `sf_sync` and `link_up` are both 1, `rx_fe_stat` takes `rx_fe_bit` one cycle later. At any other time `rx_fe_stat` holds its value.
- R2: When `sf_end` is high while sync and link are both up, `near_stat` becomes 1 one cycle later if `crc_err` is 0, and becomes 0 if `crc_err` is 1.
- R3: In any cycle where `sf_sync` or `link_up` is 0, `near_stat` is 0 one cycle later. It stays 0 until the next gated superframe end.
- R4: When `tx_mode` is 1 (forced), a `bf2_end` strobe sets `tx_fe_bit` to the software bit sampled at the last `bf8_end`.
- R5: When `tx_mode` is 0 (automatic), a `bf2_end` strobe sets `tx_fe_bit` to 0 if the sampled software bit is 0 or `near_stat` is 0. Otherwise it sets `tx_fe_bit` to 1.
- R6: `sw_fe_bit` is captured only on `bf8_end`. `tx_fe_bit` changes only one cycle after `bf2_end`, so a change of `sw_fe_bit` after `bf8_end` has no effect on the next transmitted bit.
- R7: On a gated superframe end, `fe_count` rises by 1 if `rx_fe_bit` is 0, and `ne_count` rises by 1 if `crc_err` is 1. Without such an event, and without a clear, each counter holds its value.
- R8: Each counter saturates at its all-ones value.
- R9: `cnt_clr` zeroes both counters one cycle later and takes priority over an increment in the same cycle.
- R10: After reset, `tx_fe_bit` = 1, `rx_fe_stat` = 1, `near_stat` = 0, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sf_end | input | 1 | One-cycle strobe at the end of each received superframe |
| bf8_end | input | 1 | One-cycle strobe at the end of received basic frame 8 |
| bf2_end | input | 1 | One-cycle strobe at the end of basic frame 2 (transmit update point) |
| crc_err | input | 1 | CRC error flag for the superframe ending at `sf_end` |
| rx_fe_bit | input | 1 | Received far-end error bit for the superframe ending at `sf_end` |
| sf_sync | input | 1 | Superframe sync status |
| link_up | input | 1 | Link-up status |
| tx_mode | input | 1 | 0 = automatic merge, 1 = software-forced transmit bit |
| sw_fe_bit | input | 1 | Software far-end error request (0 = error) |
| cnt_clr | input | 1 | Strobe that clears both counters |
| rx_fe_stat | output | 1 | Latched received far-end error bit |
| near_stat | output | 1 | Computed near-end status (0 = CRC error or no sync/link) |
| tx_fe_bit | output | 1 | Outgoing far-end error bit |
| fe_count | output | CNT_W | Far-end error superframe count |
| ne_count | output | CNT_W | Near-end error superframe count |

## Verification
Every output is a single register stage behind its cause. Status bits and counters are due one cycle after `sf_end`, `cnt_clr`, or a change of sync or link. `tx_fe_bit` is due one cycle after `bf2_end`. The bench drives each strobe for exactly one cycle on a falling edge. It samples on the next falling edge, just after the register has updated. For R6 it also samples between `bf8_end` and `bf2_end` to confirm nothing moved early. The bench runs the counters with a 3-bit width so that saturation is reached in a few superframes.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
  // Error status bits are active low.
  localparam logic ERR_ACT  = 1'b0;
  localparam logic ERR_IDLE = 1'b1;

  typedef enum logic {
    TX_AUTO = 1'b0,
    TX_SW   = 1'b1
  } tx_mode_e;

  localparam int unsigned N_CNT = 2;
  localparam int unsigned CNT_FE = 0;
  localparam int unsigned CNT_NE = 1;
endpackage

// File: rtl/fbe_rst_sync.sv
module fbe_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fbe_status_latch.sv
module fbe_status_latch
  import fbe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sf_end,
  input  logic gate,
  input  logic crc_err,
  input  logic rx_fe_bit,
  output logic rx_fe_q,
  output logic near_q
);
  logic rx_fe_d, near_d;
  logic upd;

  assign upd = sf_end & gate;

  always_comb begin
    rx_fe_d = rx_fe_q;
    near_d  = near_q;
    if (upd) rx_fe_d = rx_fe_bit;
    if (!gate)     near_d = ERR_ACT;
    else if (upd)  near_d = crc_err ? ERR_ACT : ERR_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_fe_q <= ERR_IDLE;
      near_q  <= ERR_ACT;
    end else begin
      rx_fe_q <= rx_fe_d;
      near_q  <= near_d;
    end
  end

  assert_rx_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_end && gate) |=> (rx_fe_q == $past(rx_fe_bit)));
  assert_rx_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sf_end && gate) |=> $stable(rx_fe_q));
  assert_near_crc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_end && gate) |=> (near_q == !$past(crc_err)));
  assert_near_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (near_q == ERR_ACT));
endmodule

// File: rtl/fbe_tx_stage.sv
module fbe_tx_stage
  import fbe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bf8_end,
  input  logic bf2_end,
  input  logic mode,
  input  logic sw_fe_bit,
  input  logic near_ok,
  output logic tx_fe_q
);
  logic smp_q, smp_d;
  logic tx_fe_d;
  logic merged;

  // Active-low OR of the two error sources is an AND of the levels.
  assign merged = smp_q & near_ok;

  always_comb begin
    smp_d   = smp_q;
    tx_fe_d = tx_fe_q;
    if (bf8_end) smp_d = sw_fe_bit;
    if (bf2_end) begin
      unique case (tx_mode_e'(mode))
        TX_SW:   tx_fe_d = smp_q;
        default: tx_fe_d = merged;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q   <= ERR_IDLE;
      tx_fe_q <= ERR_IDLE;
    end else begin
      smp_q   <= smp_d;
      tx_fe_q <= tx_fe_d;
    end
  end

  assert_tx_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bf2_end && mode) |=> (tx_fe_q == $past(smp_q)));
  assert_tx_auto_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bf2_end && !mode) |=> (tx_fe_q == ($past(smp_q) & $past(near_ok))));
  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bf2_end |=> $stable(tx_fe_q));
  assert_smp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bf8_end |=> $stable(smp_q));
endmodule

// File: rtl/fbe_err_counter.sv
module fbe_err_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (inc && !at_max) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_MAX) && !clr) |=> (cnt_q == CNT_MAX));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/fbe_status_gen.sv
module fbe_status_gen
  import fbe_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_end,
  input  logic             bf8_end,
  input  logic             bf2_end,
  input  logic             crc_err,
  input  logic             rx_fe_bit,
  input  logic             sf_sync,
  input  logic             link_up,
  input  logic             tx_mode,
  input  logic             sw_fe_bit,
  input  logic             cnt_clr,
  output logic             rx_fe_stat,
  output logic             near_stat,
  output logic             tx_fe_bit,
  output logic [CNT_W-1:0] fe_count,
  output logic [CNT_W-1:0] ne_count
);
  logic             rst_i_n;
  logic             gate;
  logic [N_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt [N_CNT];

  assign gate = sf_sync & link_up;

  always_comb begin
    inc         = '0;
    inc[CNT_FE] = sf_end & gate & (rx_fe_bit == ERR_ACT);
    inc[CNT_NE] = sf_end & gate & crc_err;
  end

  fbe_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  fbe_status_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .sf_end    (sf_end),
    .gate      (gate),
    .crc_err   (crc_err),
    .rx_fe_bit (rx_fe_bit),
    .rx_fe_q   (rx_fe_stat),
    .near_q    (near_stat)
  );

  fbe_tx_stage u_tx (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .bf8_end   (bf8_end),
    .bf2_end   (bf2_end),
    .mode      (tx_mode),
    .sw_fe_bit (sw_fe_bit),
    .near_ok   (near_stat),
    .tx_fe_q   (tx_fe_bit)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    fbe_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_i_n),
      .clr   (cnt_clr),
      .inc   (inc[g]),
      .cnt_q (cnt[g])
    );
  end

  assign fe_count = cnt[CNT_FE];
  assign ne_count = cnt[CNT_NE];
endmodule

// File: tb/sim_fbe_status_gen.sv
`timescale 1ns/1ps
module sim_fbe_status_gen;
  localparam int unsigned W = 3;
  localparam int unsigned MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic sf_end, bf8_end, bf2_end, crc_err, rx_fe_bit;
  logic sf_sync, link_up, tx_mode, sw_fe_bit, cnt_clr;
  logic rx_fe_stat, near_stat, tx_fe_bit;
  logic [W-1:0] fe_count, ne_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_fe = 0;
  int exp_ne = 0;

  always #5 clk = ~clk;

  fbe_status_gen #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sf_end(sf_end), .bf8_end(bf8_end),
    .bf2_end(bf2_end), .crc_err(crc_err), .rx_fe_bit(rx_fe_bit),
    .sf_sync(sf_sync), .link_up(link_up), .tx_mode(tx_mode),
    .sw_fe_bit(sw_fe_bit), .cnt_clr(cnt_clr), .rx_fe_stat(rx_fe_stat),
    .near_stat(near_stat), .tx_fe_bit(tx_fe_bit), .fe_count(fe_count),
    .ne_count(ne_count)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // Gated superframe end; expected counters tracked with saturation (R7, R8).
  task automatic sf(input logic crc, input logic rx);
    crc_err = crc; rx_fe_bit = rx; sf_end = 1'b1;
    cyc();
    sf_end = 1'b0;
    if (sf_sync && link_up) begin
      if (!rx && exp_fe < MAXC) exp_fe++;
      if (crc && exp_ne < MAXC) exp_ne++;
    end
  endtask

  task automatic bf8(input logic sw);
    sw_fe_bit = sw; bf8_end = 1'b1;
    cyc();
    bf8_end = 1'b0;
  endtask

  task automatic bf2();
    bf2_end = 1'b1;
    cyc();
    bf2_end = 1'b0;
  endtask

  task automatic set_gate(input logic s, input logic l);
    sf_sync = s; link_up = l;
    cyc();
  endtask

  task automatic t_reset();
    chk(tx_fe_bit, 1, "R10 tx after reset");
    chk(rx_fe_stat, 1, "R10 rx after reset");
    chk(near_stat, 0, "R10 near after reset");
    chk(fe_count, 0, "R10 fe_count after reset");
    chk(ne_count, 0, "R10 ne_count after reset");
  endtask

  task automatic t_rx_latch();
    set_gate(1, 1);
    sf(0, 0);
    chk(rx_fe_stat, 0, "R1 latch 0");
    sf(0, 1);
    chk(rx_fe_stat, 1, "R1 latch 1");
    sf(0, 0);
    set_gate(1, 0);
    sf(0, 1);
    chk(rx_fe_stat, 0, "R1 hold without link");
    set_gate(0, 1);
    sf(0, 1);
    chk(rx_fe_stat, 0, "R1 hold without sync");
    chk(fe_count, exp_fe, "R7 fe_count not gated");
  endtask

  task automatic t_near();
    set_gate(1, 1);
    sf(0, 1);
    chk(near_stat, 1, "R2 no crc error");
    sf(1, 1);
    chk(near_stat, 0, "R2 crc error");
    chk(ne_count, exp_ne, "R7 ne_count step");
    sf(0, 1);
    chk(near_stat, 1, "R2 recovered");
    set_gate(0, 1);
    chk(near_stat, 0, "R3 forced by sync loss");
    set_gate(1, 1);
    chk(near_stat, 0, "R3 stays 0 until superframe end");
    sf(0, 1);
    set_gate(1, 0);
    chk(near_stat, 0, "R3 forced by link loss");
    set_gate(1, 1);
  endtask

  task automatic t_tx_forced();
    tx_mode = 1'b1;
    sf(1, 1);  // near = 0
    bf8(0); bf2();
    chk(tx_fe_bit, 0, "R4 forced 0");
    bf8(1); bf2();
    chk(tx_fe_bit, 1, "R4 forced 1 despite near error");
  endtask

  task automatic t_tx_auto();
    tx_mode = 1'b0;
    sf(0, 1);  // near = 1
    bf8(1); bf2();
    chk(tx_fe_bit, 1, "R5 no error sources");
    bf8(0); bf2();
    chk(tx_fe_bit, 0, "R5 software request");
    sf(1, 1);  // near = 0
    bf8(1); bf2();
    chk(tx_fe_bit, 0, "R5 near-end error");
    sf(0, 1);
    bf8(1); bf2();
    chk(tx_fe_bit, 1, "R5 cleared");
  endtask

  task automatic t_tx_timing();
    tx_mode = 1'b1;
    bf8(0);
    chk(tx_fe_bit, 1, "R6 no change at bf8");
    sw_fe_bit = 1'b1;
    cyc(); cyc();
    chk(tx_fe_bit, 1, "R6 no change before bf2");
    bf2();
    chk(tx_fe_bit, 0, "R6 sampled value sent");
    tx_mode = 1'b0;
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 10; i++) sf(1, 0);
    chk(fe_count, MAXC, "R8 fe_count saturated");
    chk(ne_count, MAXC, "R8 ne_count saturated");
  endtask

  task automatic t_clear();
    cnt_clr = 1'b1;
    cyc();
    cnt_clr = 1'b0;
    exp_fe = 0; exp_ne = 0;
    chk(fe_count, 0, "R9 fe cleared");
    chk(ne_count, 0, "R9 ne cleared");
    sf(1, 0);
    chk(fe_count, 1, "R7 fe increments after clear");
    cnt_clr = 1'b1;
    sf(1, 0);
    cnt_clr = 1'b0;
    exp_fe = 0; exp_ne = 0;
    chk(fe_count, 0, "R9 clear wins over increment");
    chk(ne_count, 0, "R9 clear wins over increment ne");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    sf_end = 0; bf8_end = 0; bf2_end = 0; crc_err = 0; rx_fe_bit = 1;
    sf_sync = 0; link_up = 0; tx_mode = 0; sw_fe_bit = 1; cnt_clr = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    t_reset();
    t_rx_latch();
    t_near();
    t_tx_forced();
    t_tx_auto();
    t_tx_timing();
    t_saturate();
    t_clear();
    finish_run();
  end
endmodule